// File: doc/BRIEF.md
# Single-Slope Pulse-Height Conversion Controller

This block holds the digital half of a run-down (single-slope) pulse-height converter. A detector pulse raises a trigger line. The block then closes the analog input switch for a short acceptance window, so that the pulse can charge the hold capacitor of the peak detector. After that window it opens the switch and keeps it open for a long lockout, which gives the constant-current run-down time to finish before any new pulse can get in.

While the held voltage stays above ground, an external comparator holds its output high. The block counts one clock cycle for every cycle in which that synchronized level is high. The counter is two cascaded 4-bit stages. When the comparator drops, the count becomes the channel number. Because the run-down slope is fixed, the number of counted cycles grows in proportion to the pulse height. Each conversion reports its channel once, together with a one-cycle strobe, and raises a flag if the count ran into full scale.

The window lengths are given in microseconds and converted to clock cycles from the clock-frequency parameter. The defaults are a 100 us acceptance window and a 2000 us lockout.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, gate_o, busy_o, chan_vld_o and chan_ovf_o are 0, and chan_o is 0.
- R2: A rising edge on trig_in seen while idle makes gate_o go high 3 clock edges after the edge is applied. gate_o then stays high for exactly ACC_CYC cycles (100 for a 1 MHz clock parameter).
- R3: When the acceptance window ends, gate_o goes low and busy_o stays high for exactly DEAD_CYC more cycles (2000 for a 1 MHz clock parameter). After that the block is idle and busy_o is 0.
- R4: A trigger edge that arrives while busy_o is high is ignored. A trigger level that is held high across the return to idle does not start a new conversion. Only a fresh low-to-high transition seen in idle starts one.
- R5: An accepted trigger clears the count to 0. The count then advances by exactly one for each clock edge at which the synchronized comparator is high, so a comparator held high across N edges yields channel N.
- R6: The first comparator fall after counting has begun stores the count in chan_o and raises chan_vld_o for exactly one cycle. chan_vld_o is high 3 clock edges after the raw comparator falls.
- R7: The count saturates at 255. chan_ovf_o is 1 with a result exactly when the count reached 255, that is when N is 255 or more, and the channel reported is then 255.
- R8: Comparator activity outside an armed conversion produces no strobe and leaves chan_o unchanged. This covers activity while idle and activity after the result of the current conversion has been stored.
- R9: A longer comparator high time never yields a smaller channel, so the channel is monotonic in pulse height.
- R10: The upper 4-bit stage advances only on the carry out of the lower stage. A comparator held high across 15, 16 and 17 edges yields channels 0x0F, 0x10 and 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous pulse trigger |
| cmp_in | input | 1 | Asynchronous comparator level, high while the held voltage is above ground |
| gate_o | output | 1 | 1 = input switch closed (acceptance window) |
| busy_o | output | 1 | 1 during the acceptance window or the lockout |
| chan_o | output | 8 | Channel number of the last conversion |
| chan_ovf_o | output | 1 | Last conversion reached full scale |
| chan_vld_o | output | 1 | One-cycle strobe for a new channel |

## Verification
A wrong phase timer would show up at once as a gate or busy width that is off by some cycles. A stuck phase register would show up as a trigger that is accepted during lockout, which can be seen as a second rising edge on gate_o within a single conversion. An error in the counter or the carry chain would corrupt chan_o on the next strobe, three edges after the comparator drops. An arming flag left set would cause a stray strobe on the next comparator pulse while idle or during lockout.

// File: rtl/wilk_pkg.sv
package wilk_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCEPT = 2'd1,
    PH_LOCK   = 2'd2
  } phase_t;

  // Converts a duration in microseconds into whole clock cycles, at least one.
  function automatic int us_to_cycles(input longint clk_hz, input longint us);
    longint c;
    c = ((clk_hz / 1000) * us) / 1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/wilk_sync.sv
module wilk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wilk_gate_seq.sv
module wilk_gate_seq
  import wilk_pkg::*;
#(
  parameter int ACC_CYC  = 100,
  parameter int DEAD_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_rise,
  output logic start_o,
  output logic gate_o,
  output logic busy_o
);
  localparam int MAXC = (ACC_CYC > DEAD_CYC) ? ACC_CYC : DEAD_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] ACC_LOAD  = TW'(ACC_CYC - 1);
  localparam logic [TW-1:0] DEAD_LOAD = TW'(DEAD_CYC - 1);

  phase_t        phase_q, phase_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    phase_d = phase_q;
    tmr_d   = tmr_q;
    start_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (trig_rise) begin
          phase_d = PH_ACCEPT;
          tmr_d   = ACC_LOAD;
          start_o = 1'b1;
        end
      end
      PH_ACCEPT: begin
        if (tmr_q == '0) begin
          phase_d = PH_LOCK;
          tmr_d   = DEAD_LOAD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      PH_LOCK: begin
        if (tmr_q == '0) phase_d = PH_IDLE;
        else             tmr_d   = tmr_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
      gate_o  <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
      gate_o  <= (phase_d == PH_ACCEPT);
      busy_o  <= (phase_d != PH_IDLE);
    end
  end

  // R3: the acceptance window is left only for the lockout
  a_r3_accept_to_lock: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ACCEPT) |=> (phase_q == PH_ACCEPT || phase_q == PH_LOCK));

  // R4: no new acceptance straight out of the lockout
  a_r4_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LOCK) |=> (phase_q != PH_ACCEPT));

  // R2: the switch closes only after an idle cycle
  a_r2_gate_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> ($past(phase_q) == PH_IDLE));
endmodule

// File: rtl/wilk_cascade_cnt.sv
module wilk_cascade_cnt #(
  parameter int CNT_W   = 8,
  parameter int STAGE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam int NST = CNT_W / STAGE_W;

  logic [NST:0]         carry;
  logic [STAGE_W-1:0]   stg [NST];

  assign full_o   = &cnt_o;
  assign carry[0] = en & ~full_o;

  generate
    for (genvar i = 0; i < NST; i++) begin : g_nib
      assign carry[i+1] = carry[i] & (&stg[i]);
      always_ff @(posedge clk) begin
        if (rst || clr)    stg[i] <= '0;
        else if (carry[i]) stg[i] <= stg[i] + 1'b1;
      end
      assign cnt_o[i*STAGE_W +: STAGE_W] = stg[i];
    end
  endgenerate

  // R5: one step per enabled cycle below full scale
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (!clr && en && !full_o) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R7: full scale holds
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (!clr && full_o) |=> full_o);

  // R10: upper stages move only on the low stage carry
  a_r10_carry: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(&cnt_o[STAGE_W-1:0])) |=> $stable(cnt_o[CNT_W-1:STAGE_W]));
endmodule

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl
  import wilk_pkg::*;
#(
  parameter longint CLK_HZ    = 200_000_000,
  parameter longint ACCEPT_US = 100,
  parameter longint DEAD_US   = 2000,
  parameter int     CNT_W     = 8,
  parameter int     STAGE_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             cmp_in,
  output logic             gate_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] chan_o,
  output logic             chan_ovf_o,
  output logic             chan_vld_o
);
  localparam int ACC_CYC  = us_to_cycles(CLK_HZ, ACCEPT_US);
  localparam int DEAD_CYC = us_to_cycles(CLK_HZ, DEAD_US);

  logic [1:0]       sync_q;
  logic             trig_s, cmp_s, trig_d, cmp_d;
  logic             trig_rise, start, armed, seen, cnt_en, fall;
  logic [CNT_W-1:0] cnt;
  logic             full;

  wilk_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({trig_in, cmp_in}), .q(sync_q)
  );
  assign trig_s = sync_q[1];
  assign cmp_s  = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d <= 1'b0;
      cmp_d  <= 1'b0;
    end else begin
      trig_d <= trig_s;
      cmp_d  <= cmp_s;
    end
  end

  assign trig_rise = trig_s & ~trig_d;

  wilk_gate_seq #(.ACC_CYC(ACC_CYC), .DEAD_CYC(DEAD_CYC)) u_seq (
    .clk(clk), .rst(rst), .trig_rise(trig_rise),
    .start_o(start), .gate_o(gate_o), .busy_o(busy_o)
  );

  assign cnt_en = armed & cmp_s;
  assign fall   = armed & seen & cmp_d & ~cmp_s;

  wilk_cascade_cnt #(.CNT_W(CNT_W), .STAGE_W(STAGE_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(start), .en(cnt_en),
    .cnt_o(cnt), .full_o(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      seen       <= 1'b0;
      chan_o     <= '0;
      chan_ovf_o <= 1'b0;
      chan_vld_o <= 1'b0;
    end else begin
      chan_vld_o <= 1'b0;
      if (start) begin
        armed <= 1'b1;
        seen  <= 1'b0;
      end else if (fall) begin
        armed      <= 1'b0;
        chan_o     <= cnt;
        chan_ovf_o <= full;
        chan_vld_o <= 1'b1;
      end else begin
        if (cnt_en)  seen  <= 1'b1;
        if (!busy_o) armed <= 1'b0;
      end
    end
  end

  // R2: switch closed implies a busy conversion
  a_r2_gate_busy: assert property (@(posedge clk) disable iff (rst)
    gate_o |-> busy_o);

  // R6: strobe lasts one cycle
  a_r6_vld_single: assert property (@(posedge clk) disable iff (rst)
    chan_vld_o |=> !chan_vld_o);

  // R8: a strobe needs an armed conversion
  a_r8_vld_armed: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_vld_o) |-> $past(armed));

  // R7: overflow only with the full-scale channel
  a_r7_ovf_full: assert property (@(posedge clk) disable iff (rst)
    chan_ovf_o |-> (&chan_o));
endmodule

// File: tb/wilk_conv_ctrl_test.sv
`timescale 1ns/1ps
module wilk_conv_ctrl_test;
  localparam int ACC  = 100;
  localparam int DEAD = 2000;

  logic clk = 1'b0;
  logic rst, trig_in, cmp_in;
  logic gate_o, busy_o, chan_ovf_o, chan_vld_o;
  logic [7:0] chan_o;

  int n_cmp = 0, n_bad = 0;
  int vld_seen = 0, gate_rises = 0;
  logic gate_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wilk_conv_ctrl #(.CLK_HZ(1_000_000)) uut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cmp_in(cmp_in),
    .gate_o(gate_o), .busy_o(busy_o), .chan_o(chan_o),
    .chan_ovf_o(chan_ovf_o), .chan_vld_o(chan_vld_o)
  );

  always @(negedge clk) begin
    if (chan_vld_o) vld_seen++;
    if (gate_o && !gate_prev) gate_rises++;
    gate_prev <= gate_o;
  end

  function automatic int exp_chan(input int n);
    return (n >= 255) ? 255 : n;
  endfunction

  function automatic bit exp_ovf(input int n);
    return n >= 255;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy_o && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  // one conversion with comparator high across n edges
  task automatic run_pulse(input int n, input int dly, output int res);
    int lat, g0, v0;
    g0 = gate_rises;
    trig_in = 1'b1; tick(2); trig_in = 1'b0;
    tick(dly);
    cmp_in = 1'b1; tick(n); cmp_in = 1'b0;
    lat = 0;
    v0 = vld_seen;
    while (!chan_vld_o && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 3, "R6 valid latency", lat, 3);
    res = chan_o;
    check(int'(chan_o) == exp_chan(n), (n == 16 || n == 15 || n == 17) ? "R10 channel" : "R5 channel",
          chan_o, exp_chan(n));
    check(chan_ovf_o == exp_ovf(n), "R7 overflow flag", chan_ovf_o, exp_ovf(n));
    tick(1);
    check(chan_vld_o == 1'b0, "R6 strobe width", chan_vld_o, 0);
    // stimulus during lockout must be ignored
    v0 = vld_seen;
    if (busy_o) begin
      trig_in = 1'b1; tick(3); trig_in = 1'b0;
      tick(2);
      cmp_in = 1'b1; tick(10); cmp_in = 1'b0;
      tick(6);
    end
    wait_idle();
    tick(2);
    check(vld_seen == v0, "R8 no strobe after result", vld_seen - v0, 0);
    check(int'(chan_o) == exp_chan(n), "R8 result held", chan_o, exp_chan(n));
    check(gate_rises - g0 == 1, "R4 single acceptance", gate_rises - g0, 1);
  endtask

  initial begin
    int w, gh, dh, r, prev_n, prev_r, v0;
    rst = 1'b1; trig_in = 1'b0; cmp_in = 1'b0;
    tick(4);
    check(gate_o == 0 && busy_o == 0, "R1 gate/busy in reset", {gate_o, busy_o}, 0);
    check(chan_vld_o == 0 && chan_ovf_o == 0, "R1 flags in reset", {chan_vld_o, chan_ovf_o}, 0);
    rst = 1'b0;
    tick(1);
    check(chan_o == 0 && !gate_o, "R1 after reset", chan_o, 0);
    tick(3);

    // gate waveform, trigger held high throughout
    trig_in = 1'b1;
    w = 0;
    while (!gate_o && w < 20) begin @(negedge clk); w++; end
    check(w == 3, "R2 gate delay", w, 3);
    gh = 0;
    while (gate_o && gh < 5000) begin @(negedge clk); gh++; end
    check(gh == ACC, "R2 acceptance width", gh, ACC);
    dh = 0;
    while (busy_o && !gate_o && dh < 5000) begin @(negedge clk); dh++; end
    check(dh == DEAD, "R3 lockout width", dh, DEAD);
    check(busy_o == 0, "R3 idle after lockout", busy_o, 0);
    tick(50);
    check(busy_o == 0 && gate_rises == 1, "R4 held level no restart", gate_rises, 1);
    trig_in = 1'b0;
    tick(5);

    // comparator while idle
    v0 = vld_seen;
    cmp_in = 1'b1; tick(20); cmp_in = 1'b0; tick(8);
    check(vld_seen == v0, "R8 idle comparator strobe", vld_seen - v0, 0);
    check(chan_o == 0, "R8 idle comparator result", chan_o, 0);

    // directed corners
    run_pulse(1, 0, r);
    run_pulse(15, 4, r);
    run_pulse(16, 10, r);
    run_pulse(17, 2, r);
    run_pulse(254, 0, r);
    run_pulse(255, 7, r);
    run_pulse(256, 3, r);
    run_pulse(300, 1, r);

    // constrained random amplitudes
    void'($urandom(32'd2024));
    prev_n = 0; prev_r = 0;
    for (int i = 0; i < 12; i++) begin
      int n, d;
      n = int'($urandom_range(300, 1));
      d = int'($urandom_range(60, 0));
      run_pulse(n, d, r);
      if (i > 0) begin
        if (n > prev_n)      check(r >= prev_r, "R9 monotonic", r, prev_r);
        else if (n < prev_n) check(r <= prev_r, "R9 monotonic", r, prev_r);
      end
      prev_n = n; prev_r = r;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule